// File: doc/BRIEF.md
# Delayed Branch Resolution Unit

This unit decides the outcome of every control-transfer instruction in a 64-bit pipeline that has one branch delay slot. Each cycle it may accept one instruction word. With the word come the two register operand values, the address of the delay-slot instruction and one coprocessor condition bit. The unit decodes the word and evaluates the condition. It then registers the result: a taken flag, the next fetch address, a flag that cancels the delay-slot instruction, and a request to write the return address to a register.

The "likely" forms cancel the delay-slot instruction when the branch is not taken. All other forms always let the delay-slot instruction run. The linking forms write the address after the delay slot to their link register whether or not the branch is taken. A word that is not a control transfer yields a plain fall-through result, so the fetch stage can send every word through the unit.

Top module: `branch_resolve`

## Requirements
- R1: A word presented with `in_valid` high produces its result with `out_valid` high exactly one clock later. A cycle with `in_valid` low produces `out_valid`, `taken`, `annul` and `link_we` all low one clock later. After reset all four are low.
- R2: A conditional branch targets the delay-slot address plus the 16-bit offset (bits 15:0), sign-extended and shifted left by 2. When a control transfer is not taken, or the word is not a control transfer, `next_pc` is the delay-slot address plus 4.
- R3: Opcode (bits 31:26) 4 is taken when rs equals rt, and opcode 5 is taken when they differ. Opcodes 20 and 21 are the likely forms of these two.
- R4: Opcode 6 is taken when rs is at most zero and opcode 7 when rs is above zero, with rs read as signed. Opcodes 22 and 23 are the likely forms.
- R5: Opcode 1 takes its variant from the rt field (bits 20:16). Bit 16 set tests rs ≥ 0, and clear tests rs < 0, signed. Bit 17 marks the likely form. Bit 20 marks a form that links to register 31. Any word in this group with bit 18 or bit 19 set is not a control transfer.
- R6: `annul` is high only for a likely form whose condition is false. It is never high for a taken branch or for a non-likely form.
- R7: A linking form sets `link_we` with `link_val` equal to the delay-slot address plus 4, whether or not it is taken.
- R8: Opcodes 2 and 3 are always taken. The target is the upper 36 bits of the delay-slot address joined to the 26-bit index (bits 25:0) shifted left by 2. Opcode 3 links to register 31.
- R9: Opcode 0 with bits 10:6 zero and function (bits 5:0) 8 or 9 jumps to the rs value. Function 9 links to the register named by bits 15:11.
- R10: Opcodes 16 to 19 with bits 25:21 equal to 8 test `cop_cond`. Bit 16 set branches when the bit is true, and clear branches when it is false. Bit 17 marks the likely form. The branch target follows R2.
- R11: Any other word gives `taken`, `annul` and `link_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| rs_val | input | 64 | Value of the rs operand |
| rt_val | input | 64 | Value of the rt operand |
| slot_pc | input | 64 | Address of the delay-slot instruction |
| cop_cond | input | 1 | Coprocessor condition bit |
| out_valid | output | 1 | Result is present |
| taken | output | 1 | Control transfer is taken |
| annul | output | 1 | Cancel the delay-slot instruction |
| next_pc | output | 64 | Next fetch address |
| link_we | output | 1 | Write request for the link register |
| link_reg | output | 5 | Link register number |
| link_val | output | 64 | Return address to write |

## Verification
Every result is due exactly one clock after the word that causes it, because a single output register lies between the inputs and the ports. The bench drives each word on a falling edge and puts the reference model's prediction in a queue. On the next falling edge, one full clock later, it pops that prediction and compares it with the ports. Idle cycles also go through the queue, so an extra or missing cycle of delay shows up as a mismatch. Every variant is run both taken and not taken, so each annul and link case is seen in both outcomes.

// File: rtl/branch_resolve_pkg.sv
// Shared types for the branch resolution unit.
// Assumes the 32-bit instruction word layout with a 6-bit major opcode.
package branch_resolve_pkg;
    localparam int OPC_W = 6;
    localparam int REG_W = 5;
    localparam int OFF_W = 16;
    localparam int IDX_W = 26;

    // Kind of control transfer.
    typedef enum logic [1:0] {
        XFER_NONE = 2'd0,
        XFER_COND = 2'd1,
        XFER_JIDX = 2'd2,
        XFER_JREG = 2'd3
    } xfer_e;

    // Condition to evaluate.
    typedef enum logic [3:0] {
        TST_ALWAYS, TST_EQ, TST_NE, TST_LEZ, TST_GTZ,
        TST_LTZ, TST_GEZ, TST_CTRUE, TST_CFALSE
    } test_e;

    typedef struct packed {
        xfer_e             kind;
        test_e             test;
        logic              likely;
        logic              link;
        logic [REG_W-1:0]  link_reg;
    } ctrl_t;
endpackage

// File: rtl/br_decode.sv
// Decodes one instruction word into a control-transfer descriptor.
// Assumes words that are not recognised are ordinary instructions (kind NONE).
module br_decode
    import branch_resolve_pkg::*;
(
    input  logic [31:0] instr,
    output ctrl_t       ctrl
);
    logic [OPC_W-1:0] opc;
    logic [REG_W-1:0] f_rs, f_rt, f_rd;
    logic [4:0]       f_sh;
    logic [5:0]       f_fn;

    assign opc  = instr[31:26];
    assign f_rs = instr[25:21];
    assign f_rt = instr[20:16];
    assign f_rd = instr[15:11];
    assign f_sh = instr[10:6];
    assign f_fn = instr[5:0];

    // Map opcode groups onto kind, test, likely and link attributes.
    always_comb begin
        ctrl = '{kind: XFER_NONE, test: TST_ALWAYS, likely: 1'b0,
                 link: 1'b0, link_reg: 5'd31};
        unique casez (opc)
            6'b000000: begin
                if (f_sh == 5'd0 && f_fn[5:1] == 5'b00100) begin
                    ctrl.kind     = XFER_JREG;
                    ctrl.link     = f_fn[0];
                    ctrl.link_reg = f_rd;
                end
            end
            6'b000001: begin
                if (f_rt[3:2] == 2'b00) begin
                    ctrl.kind   = XFER_COND;
                    ctrl.test   = f_rt[0] ? TST_GEZ : TST_LTZ;
                    ctrl.likely = f_rt[1];
                    ctrl.link   = f_rt[4];
                end
            end
            6'b00001?: begin
                ctrl.kind = XFER_JIDX;
                ctrl.link = opc[0];
            end
            6'b0?01??: begin
                ctrl.kind   = XFER_COND;
                ctrl.likely = opc[4];
                unique case (opc[1:0])
                    2'd0:    ctrl.test = TST_EQ;
                    2'd1:    ctrl.test = TST_NE;
                    2'd2:    ctrl.test = TST_LEZ;
                    default: ctrl.test = TST_GTZ;
                endcase
            end
            6'b0100??: begin
                if (f_rs == 5'b01000) begin
                    ctrl.kind   = XFER_COND;
                    ctrl.test   = f_rt[0] ? TST_CTRUE : TST_CFALSE;
                    ctrl.likely = f_rt[1];
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/br_cond.sv
// Evaluates a branch test on the operands; zero tests read rs as signed.
module br_cond
    import branch_resolve_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  test_e           test,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    input  logic            cop_cond,
    output logic            hit
);
    logic neg, zero;
    assign neg  = rs_val[XLEN-1];
    assign zero = (rs_val == '0);

    // Select the outcome for the requested test.
    always_comb begin
        unique case (test)
            TST_EQ:     hit = (rs_val == rt_val);
            TST_NE:     hit = (rs_val != rt_val);
            TST_LEZ:    hit = neg | zero;
            TST_GTZ:    hit = ~neg & ~zero;
            TST_LTZ:    hit = neg;
            TST_GEZ:    hit = ~neg;
            TST_CTRUE:  hit = cop_cond;
            TST_CFALSE: hit = ~cop_cond;
            default:    hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/br_target.sv
// Forms the relative, index and fall-through addresses from the delay-slot address.
// Assumes word-aligned instructions (offset and index scaled by 4).
module br_target
    import branch_resolve_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]  slot_pc,
    input  logic [OFF_W-1:0] offset,
    input  logic [IDX_W-1:0] index,
    output logic [XLEN-1:0]  rel_pc,
    output logic [XLEN-1:0]  idx_pc,
    output logic [XLEN-1:0]  seq_pc
);
    localparam int KEEP = XLEN - IDX_W - 2;
    logic [XLEN-1:0] off_ext;

    // Scale and sign-extend the offset, then form the three candidate addresses.
    always_comb begin
        off_ext = {{(XLEN-OFF_W-2){offset[OFF_W-1]}}, offset, 2'b00};
        rel_pc  = slot_pc + off_ext;
        idx_pc  = {slot_pc[XLEN-1 -: KEEP], index, 2'b00};
        seq_pc  = slot_pc + XLEN'(4);
    end
endmodule

// File: rtl/branch_resolve.sv
// Branch resolution unit for a pipeline with one delay slot.
// Registers one result per accepted word; assumes operands are already forwarded.
module branch_resolve
    import branch_resolve_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    input  logic [XLEN-1:0] slot_pc,
    input  logic            cop_cond,
    output logic            out_valid,
    output logic            taken,
    output logic            annul,
    output logic [XLEN-1:0] next_pc,
    output logic            link_we,
    output logic [4:0]      link_reg,
    output logic [XLEN-1:0] link_val
);
    ctrl_t           ctrl;
    logic            hit, go;
    logic [XLEN-1:0] rel_pc, idx_pc, seq_pc, dest;

    br_decode u_dec (.instr(instr), .ctrl(ctrl));

    br_cond #(.XLEN(XLEN)) u_cond (
        .test(ctrl.test), .rs_val(rs_val), .rt_val(rt_val),
        .cop_cond(cop_cond), .hit(hit)
    );

    br_target #(.XLEN(XLEN)) u_tgt (
        .slot_pc(slot_pc), .offset(instr[OFF_W-1:0]), .index(instr[IDX_W-1:0]),
        .rel_pc(rel_pc), .idx_pc(idx_pc), .seq_pc(seq_pc)
    );

    // Choose the next fetch address from the transfer kind and outcome.
    always_comb begin
        go = (ctrl.kind != XFER_NONE) && hit;
        unique case (ctrl.kind)
            XFER_COND: dest = rel_pc;
            XFER_JIDX: dest = idx_pc;
            XFER_JREG: dest = rs_val;
            default:   dest = seq_pc;
        endcase
        if (!go) dest = seq_pc;
    end

    // Result register; flags are cleared on reset and on idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            taken     <= 1'b0;
            annul     <= 1'b0;
            link_we   <= 1'b0;
            link_reg  <= '0;
            next_pc   <= '0;
            link_val  <= '0;
        end else begin
            out_valid <= in_valid;
            taken     <= in_valid & go;
            annul     <= in_valid & (ctrl.kind != XFER_NONE) & ctrl.likely & ~go;
            link_we   <= in_valid & (ctrl.kind != XFER_NONE) & ctrl.link;
            link_reg  <= ctrl.link_reg;
            next_pc   <= dest;
            link_val  <= seq_pc;
        end
    end

    // R1
    result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !taken && !annul && !link_we);
    // R6
    annul_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        annul |-> !taken && out_valid);
    // R7
    link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid ##1 link_we |-> link_val == $past(slot_pc) + XLEN'(4));
    // R2
    fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid ##1 !taken |-> next_pc == $past(slot_pc) + XLEN'(4));
endmodule

// File: tb/sim_branch_resolve.sv
module sim_branch_resolve;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] rs_val = '0, rt_val = '0, slot_pc = '0;
    logic        cop_cond = 1'b0;
    logic        out_valid, taken, annul, link_we;
    logic [63:0] next_pc, link_val;
    logic [4:0]  link_reg;

    int total = 0, bad = 0, cycles = 0;

    typedef struct {
        bit v; bit tk; bit an; bit lw;
        logic [4:0] lr; logic [63:0] np; logic [63:0] lv;
        string req;
    } exp_t;
    exp_t pend[$];

    always #5 clk = ~clk;

    branch_resolve #(.XLEN(64)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .slot_pc(slot_pc), .cop_cond(cop_cond),
        .out_valid(out_valid), .taken(taken), .annul(annul), .next_pc(next_pc),
        .link_we(link_we), .link_reg(link_reg), .link_val(link_val)
    );

    // Behavioural prediction taken from the requirement text.
    function automatic exp_t predict(bit v, logic [31:0] w, logic [63:0] a,
                                     logic [63:0] b, logic [63:0] pc, bit cc, string req);
        exp_t e;
        int op = int'(w[31:26]);
        longint sa = longint'(a);
        bit br = 0, cond = 0, lk = 0, lnk = 0;
        logic [63:0] tgt = 64'd0;
        logic [63:0] rel = pc + {{46{w[15]}}, w[15:0], 2'b00};
        e.v = v; e.req = req; e.lr = 5'd31;
        if (op == 0 && w[10:6] == 0 && (w[5:0] == 8 || w[5:0] == 9)) begin
            br = 1; cond = 1; tgt = a; lnk = (w[5:0] == 9); e.lr = w[15:11];
        end else if (op == 1 && w[19:18] == 0) begin
            br = 1; tgt = rel; cond = w[16] ? (sa >= 0) : (sa < 0);
            lk = w[17]; lnk = w[20];
        end else if (op == 2 || op == 3) begin
            br = 1; cond = 1; lnk = (op == 3);
            tgt = {pc[63:28], w[25:0], 2'b00};
        end else if ((op >= 4 && op <= 7) || (op >= 20 && op <= 23)) begin
            br = 1; tgt = rel; lk = (op >= 20);
            case (op % 4)
                0: cond = (a == b);
                1: cond = (a != b);
                2: cond = (sa <= 0);
                default: cond = (sa > 0);
            endcase
        end else if (op >= 16 && op <= 19 && w[25:21] == 8) begin
            br = 1; tgt = rel; lk = w[17]; cond = w[16] ? cc : !cc;
        end
        e.tk = br && cond;
        e.an = br && lk && !cond;
        e.lw = lnk;
        e.np = e.tk ? tgt : pc + 64'd4;
        e.lv = pc + 64'd4;
        return e;
    endfunction

    task automatic compare_front();
        exp_t e;
        bit ok;
        if (pend.size() == 0) return;
        e = pend.pop_front();
        total++;
        if (e.v)
            ok = out_valid && taken == e.tk && annul == e.an && next_pc == e.np &&
                 link_we == e.lw && (!e.lw || (link_reg == e.lr && link_val == e.lv));
        else
            ok = !out_valid && !taken && !annul && !link_we;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got v=%0b tk=%0b an=%0b np=%h lw=%0b lr=%0d lv=%h exp v=%0b tk=%0b an=%0b np=%h lw=%0b lr=%0d lv=%h",
                     e.req, out_valid, taken, annul, next_pc, link_we, link_reg, link_val,
                     e.v, e.tk, e.an, e.np, e.lw, e.lr, e.lv);
        end
    endtask

    // One cycle: check the previous result, then drive and predict the next word.
    task automatic step(bit v, logic [31:0] w, logic [63:0] a, logic [63:0] b,
                        logic [63:0] pc, bit cc, string req);
        @(negedge clk);
        compare_front();
        in_valid = v; instr = w; rs_val = a; rt_val = b; slot_pc = pc; cop_cond = cc;
        pend.push_back(predict(v, w, a, b, pc, cc, req));
    endtask

    function automatic logic [31:0] ienc(int op, int rs, int rt, int off);
        return {op[5:0], rs[4:0], rt[4:0], off[15:0]};
    endfunction

    always @(posedge clk) cycles++;

    // Watchdog: an expired run counts as a failed check.
    initial begin
        wait (cycles >= 20000);
        bad++; total++;
        $display("FAIL watchdog: got cycles=%0d exp done", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] vals[4];
        vals[0] = -64'sd3; vals[1] = 64'd0; vals[2] = 64'd9; vals[3] = 64'd5;
        repeat (3) @(negedge clk);
        total++;
        if (out_valid || taken || annul || link_we) begin
            bad++;
            $display("FAIL R1 reset: got v=%0b tk=%0b an=%0b lw=%0b exp all 0",
                     out_valid, taken, annul, link_we);
        end
        rst_n = 1'b1;
        // R3 R4 R6: two-operand and signed zero tests, normal and likely forms
        foreach (vals[i]) begin
            for (int op = 4; op <= 23; op++) begin
                if (op > 7 && op < 20) continue;
                step(1, ienc(op, 4, 5, 16'h0010), vals[i], 64'd5, 64'h0000_0010_0000_1000, 0,
                     (op % 4) < 2 ? "R3" : "R4");
                step(1, ienc(op, 4, 5, 16'hfff8), vals[i], 64'd7, 64'h0000_0010_0000_1000, 0, "R2");
            end
        end
        // R5 R7: selector group, link to 31 in both outcomes
        foreach (vals[i]) begin
            for (int rt = 0; rt < 32; rt++)
                step(1, ienc(1, 3, rt, 16'h0123), vals[i], 64'd0, 64'h8000_0000_0040_0000, 0,
                     rt[4] ? "R7" : "R5");
        end
        // R10: coprocessor condition, all four forms, both condition values
        for (int z = 16; z <= 19; z++)
            for (int rt = 0; rt < 4; rt++)
                for (int cc = 0; cc < 2; cc++)
                    step(1, ienc(z, 8, rt, 16'h8000), 64'd1, 64'd2, 64'h0000_0000_2000_0000, cc[0], "R10");
        step(1, ienc(17, 4, 1, 16'h0004), 64'd1, 64'd2, 64'h100, 1, "R11");
        // R8: index jumps
        step(1, {6'd2, 26'h3ff_ffff}, 64'd0, 64'd0, 64'habcd_0000_1234_5678, 0, "R8");
        step(1, {6'd3, 26'h000_0101}, 64'd0, 64'd0, 64'habcd_0000_f234_5678, 0, "R8");
        // R9: register jumps, with and without a link
        step(1, {6'd0, 5'd4, 5'd0, 5'd0, 5'd0, 6'd8}, 64'hdead_beef_0000_4000, 64'd0, 64'h300, 0, "R9");
        step(1, {6'd0, 5'd4, 5'd0, 5'd31, 5'd0, 6'd9}, 64'h0000_0000_0000_8000, 64'd0, 64'h400, 0, "R9");
        step(1, {6'd0, 5'd4, 5'd0, 5'd7, 5'd0, 6'd9}, 64'h0000_0000_0000_9000, 64'd0, 64'h500, 0, "R9");
        step(1, {6'd0, 5'd4, 5'd0, 5'd7, 5'd3, 6'd9}, 64'h0000_0000_0000_9000, 64'd0, 64'h500, 0, "R11");
        // R11: ordinary words
        step(1, {6'd0, 5'd1, 5'd2, 5'd3, 5'd0, 6'd32}, 64'd1, 64'd1, 64'h600, 1, "R11");
        step(1, ienc(8, 1, 2, 16'h0040), 64'd1, 64'd1, 64'h700, 1, "R11");
        // R1: idle cycles between words
        step(0, ienc(4, 1, 1, 16'h0040), 64'd1, 64'd1, 64'h800, 0, "R1");
        step(1, ienc(4, 1, 1, 16'h0040), 64'd1, 64'd1, 64'h800, 0, "R1");
        step(0, {6'd3, 26'd5}, 64'd0, 64'd0, 64'h900, 0, "R1");
        step(0, 32'd0, 64'd0, 64'd0, 64'd0, 0, "R1");
        @(negedge clk);
        compare_front();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule